// File: doc/BRIEF.md
# Shift-Rotate Register Through Carry

This block is the holding register that sits behind an arithmetic unit. On each clock it either takes the unit's result into its register unchanged, or it moves its current contents by one bit position. Four control inputs choose the action: the direction of the move, whether to move or load, whether bits wrap around, and an active-low request to clear the carry bit.

The two wrap modes behave differently. A left rotation goes through the carry bit, so the register and the carry form one nine-bit ring. A right rotation wraps bit 0 back into bit 7 inside the register and leaves the carry alone. A left shift without wrap drops the top bit into the carry. A right shift without wrap fills the top bit with zero and leaves the carry alone. The block never touches the arithmetic unit's other result flags. The register contents and the carry bit are its only outputs.

Top module: `shrot_carry_reg`

## Requirements
- R1: While `shift_en` is 0, a rising clock edge copies `din` into `q` unchanged.
- R2: While `shift_en` is 1, each rising edge performs exactly one single-position step and ignores `din`. The step goes right when `dir_right` is 1 and left when it is 0.
- R3: A left step with `rot_en` 0 moves each bit up one place, writes 0 into bit 0 and moves the old top bit into `carry_o`.
- R4: A left step with `rot_en` 1 moves each bit up one place, writes the old `carry_o` into bit 0 and moves the old top bit into `carry_o`. Nine such steps restore both `q` and `carry_o`.
- R5: A right step with `rot_en` 1 moves each bit down one place and writes the old bit 0 into the top bit. `carry_o` keeps its value, and eight such steps restore `q`.
- R6: A right step with `rot_en` 0 moves each bit down one place and writes 0 into the top bit. `carry_o` keeps its value.
- R7: When `clr_carry_n` is 0 at a rising edge, `carry_o` becomes 0, whatever value the selected action would have written to it. The data part of that action still takes place.
- R8: A load with `clr_carry_n` 1 leaves `carry_o` unchanged.
- R9: When `rst` (active high, synchronous) is 1 at a rising edge, both `q` and `carry_o` become 0, and this takes priority over every other control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| din | input | WIDTH (8) | Parallel data to load |
| shift_en | input | 1 | 1 = perform one step, 0 = load `din` |
| dir_right | input | 1 | 1 = step right, 0 = step left |
| rot_en | input | 1 | 1 = rotate (wrap), 0 = plain shift |
| clr_carry_n | input | 1 | 0 = force carry to 0 this edge |
| q | output | WIDTH (8) | Register contents |
| carry_o | output | 1 | Carry bit |

## Verification
A sequence of loads, shifts and rotations is run with values whose bits alternate. With such values, a fill bit of 0 is easy to tell from a wrapped bit or a carried-in bit. The junk values on `din` during steps show that data input is ignored. Two steps are run with the carry set to 1: a right step and a load. They separate the direction that updates the carry from the direction that bypasses it. A rotate left with the clear request low shows that the clear takes priority while the old carry still enters bit 0. Full loops of nine left rotations and eight right rotations confirm the ring lengths. A reset applied in the middle of a run confirms that reset overrides a pending step.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

  typedef enum logic [2:0] {
    ACT_LOAD = 3'd0,
    ACT_SHL  = 3'd1,
    ACT_ROL  = 3'd2,
    ACT_SHR  = 3'd3,
    ACT_ROR  = 3'd4
  } shrot_act_e;

  function automatic shrot_act_e pick_action(input logic shift_en,
                                             input logic dir_right,
                                             input logic rot_en);
    if (!shift_en)       return ACT_LOAD;
    else if (dir_right)  return rot_en ? ACT_ROR : ACT_SHR;
    else                 return rot_en ? ACT_ROL : ACT_SHL;
  endfunction

  function automatic logic action_moves_carry(input shrot_act_e act);
    return (act == ACT_SHL) || (act == ACT_ROL);
  endfunction

endpackage

// File: rtl/shrot_decode.sv
module shrot_decode
  import shrot_pkg::*;
(
  input  logic       shift_en,
  input  logic       dir_right,
  input  logic       rot_en,
  output shrot_act_e act,
  output logic       carry_touch
);

  always_comb begin
    act         = pick_action(shift_en, dir_right, rot_en);
    carry_touch = action_moves_carry(act);
  end

endmodule

// File: rtl/shrot_datapath.sv
module shrot_datapath
  import shrot_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  shrot_act_e       act,
  input  logic [WIDTH-1:0] din,
  input  logic [WIDTH-1:0] cur,
  input  logic             carry_in,
  output logic [WIDTH-1:0] nxt,
  output logic             carry_out
);

  localparam int MSB = WIDTH - 1;

  function automatic logic [WIDTH-1:0] step_left(input logic [WIDTH-1:0] v,
                                                 input logic fill);
    return {v[MSB-1:0], fill};
  endfunction

  function automatic logic [WIDTH-1:0] step_right(input logic [WIDTH-1:0] v,
                                                  input logic fill);
    return {fill, v[MSB:1]};
  endfunction

  always_comb begin
    carry_out = cur[MSB];
    unique case (act)
      ACT_LOAD: nxt = din;
      ACT_SHL:  nxt = step_left(cur, 1'b0);
      ACT_ROL:  nxt = step_left(cur, carry_in);
      ACT_SHR:  nxt = step_right(cur, 1'b0);
      ACT_ROR:  nxt = step_right(cur, cur[0]);
      default:  nxt = cur;
    endcase
  end

endmodule

// File: rtl/shrot_carry_ff.sv
module shrot_carry_ff (
  input  logic clk,
  input  logic rst,
  input  logic clr_n,
  input  logic upd,
  input  logic d,
  output logic c
);

  always_ff @(posedge clk) begin
    if (rst)         c <= 1'b0;
    else if (!clr_n) c <= 1'b0;
    else if (upd)    c <= d;
  end

endmodule

// File: rtl/shrot_carry_reg.sv
module shrot_carry_reg
  import shrot_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  input  logic             shift_en,
  input  logic             dir_right,
  input  logic             rot_en,
  input  logic             clr_carry_n,
  output logic [WIDTH-1:0] q,
  output logic             carry_o
);

  shrot_act_e       act;
  logic             carry_touch;
  logic [WIDTH-1:0] q_next;
  logic             carry_next;

  shrot_decode u_dec (
    .shift_en    (shift_en),
    .dir_right   (dir_right),
    .rot_en      (rot_en),
    .act         (act),
    .carry_touch (carry_touch)
  );

  shrot_datapath #(.WIDTH(WIDTH)) u_dp (
    .act       (act),
    .din       (din),
    .cur       (q),
    .carry_in  (carry_o),
    .nxt       (q_next),
    .carry_out (carry_next)
  );

  shrot_carry_ff u_cf (
    .clk   (clk),
    .rst   (rst),
    .clr_n (clr_carry_n),
    .upd   (carry_touch),
    .d     (carry_next),
    .c     (carry_o)
  );

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= q_next;
  end

endmodule

// File: rtl/shrot_carry_reg_chk.sv
module shrot_carry_reg_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] din,
  input logic             shift_en,
  input logic             dir_right,
  input logic             rot_en,
  input logic             clr_carry_n,
  input logic [WIDTH-1:0] q,
  input logic             carry_o,
  input logic             carry_touch
);

  localparam int MSB = WIDTH - 1;

  assert_load_R1: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> q == $past(din));

  assert_shl_data_R3: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !dir_right && !rot_en) |=> q == {$past(q[MSB-1:0]), 1'b0});

  assert_left_carry_R3: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !dir_right && clr_carry_n) |=> carry_o == $past(q[MSB]));

  assert_rol_fill_R4: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !dir_right && rot_en) |=> q[0] == $past(carry_o));

  assert_ror_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    (shift_en && dir_right && rot_en) |=> q == {$past(q[0]), $past(q[MSB:1])});

  assert_shr_fill_R6: assert property (@(posedge clk) disable iff (rst)
    (shift_en && dir_right && !rot_en) |=> q == {1'b0, $past(q[MSB:1])});

  assert_right_keeps_carry_R5: assert property (@(posedge clk) disable iff (rst)
    (shift_en && dir_right && clr_carry_n) |=> $stable(carry_o));

  assert_no_touch_right_R6: assert property (@(posedge clk) disable iff (rst)
    (shift_en && dir_right) |-> !carry_touch);

  assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
    !clr_carry_n |=> !carry_o);

  assert_load_keeps_carry_R8: assert property (@(posedge clk) disable iff (rst)
    (!shift_en && clr_carry_n) |=> $stable(carry_o));

  assert_reset_R9: assert property (@(posedge clk)
    rst |=> (q == '0 && !carry_o));

endmodule

bind shrot_carry_reg shrot_carry_reg_chk #(.WIDTH(WIDTH)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .din         (din),
  .shift_en    (shift_en),
  .dir_right   (dir_right),
  .rot_en      (rot_en),
  .clr_carry_n (clr_carry_n),
  .q           (q),
  .carry_o     (carry_o),
  .carry_touch (carry_touch)
);

// File: tb/shrot_carry_reg_tb.sv
module shrot_carry_reg_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int NVEC = 15;

  // {req[3:0], shift_en, dir_right, rot_en, clr_n, din[7:0], exp_q[7:0], exp_c}
  localparam logic [24:0] VEC [NVEC] = '{
    {4'd1, 4'b0001, 8'hA5, 8'hA5, 1'b0},  // R1 load
    {4'd3, 4'b1001, 8'h5A, 8'h4A, 1'b1},  // R3 logical left, din ignored (R2)
    {4'd4, 4'b1011, 8'h33, 8'h95, 1'b0},  // R4 rotate left, carry in to bit 0
    {4'd4, 4'b1011, 8'h00, 8'h2A, 1'b1},  // R4
    {4'd5, 4'b1111, 8'hFF, 8'h15, 1'b1},  // R5 rotate right, carry kept
    {4'd5, 4'b1111, 8'h00, 8'h8A, 1'b1},  // R5 bit 0 wraps to top
    {4'd6, 4'b1101, 8'hC3, 8'h45, 1'b1},  // R6 shift right zero fill
    {4'd8, 4'b0001, 8'h3C, 8'h3C, 1'b1},  // R8 load keeps carry
    {4'd7, 4'b0000, 8'h81, 8'h81, 1'b0},  // R7 clear during load
    {4'd2, 4'b1001, 8'h77, 8'h02, 1'b1},  // R2 left step
    {4'd7, 4'b1010, 8'h00, 8'h05, 1'b0},  // R7 priority over rotate-left carry
    {4'd2, 4'b1101, 8'hEE, 8'h02, 1'b0},  // R2 right step
    {4'd1, 4'b0001, 8'hFF, 8'hFF, 1'b0},  // R1
    {4'd3, 4'b1001, 8'h00, 8'hFE, 1'b1},  // R3
    {4'd7, 4'b1100, 8'h00, 8'h7F, 1'b0}   // R7 clear with right shift
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] din = '0;
  logic         shift_en = 1'b0;
  logic         dir_right = 1'b0;
  logic         rot_en = 1'b0;
  logic         clr_carry_n = 1'b1;
  logic [W-1:0] q;
  logic         carry_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shrot_carry_reg #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .din(din), .shift_en(shift_en),
    .dir_right(dir_right), .rot_en(rot_en), .clr_carry_n(clr_carry_n),
    .q(q), .carry_o(carry_o)
  );

  task automatic check(input string req, input logic [W-1:0] eq, input logic ec);
    checks++;
    if (q !== eq || carry_o !== ec) begin
      errors++;
      $display("FAIL %s: q=%h c=%b expected q=%h c=%b", req, q, carry_o, eq, ec);
    end
  endtask

  task automatic step(input logic [3:0] ctl, input logic [W-1:0] d);
    {shift_en, dir_right, rot_en, clr_carry_n} = ctl;
    din = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R9 reset state", 8'h00, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][20:17], VEC[i][16:9]);
      check($sformatf("R%0d vector %0d", VEC[i][24:21], i), VEC[i][8:1], VEC[i][0]);
    end

    // R4: nine left rotations close the nine-bit ring
    step(4'b0001, 8'h96);
    step(4'b1001, 8'h00);          // q=2C, c=1
    check("R3 setup", 8'h2C, 1'b1);
    for (int k = 0; k < 9; k++) step(4'b1011, 8'h00);
    check("R4 nine-step ring", 8'h2C, 1'b1);
    step(4'b1011, 8'h00);
    check("R4 single step carry in", 8'h59, 1'b0);

    // R5: eight right rotations restore q, carry untouched
    step(4'b0001, 8'hB4);
    for (int k = 0; k < 8; k++) step(4'b1111, 8'h00);
    check("R5 eight-step wrap", 8'hB4, 1'b0);

    // R9: reset overrides a pending step
    step(4'b1001, 8'h00);          // B4 -> 68, c=1
    check("R3 before reset", 8'h68, 1'b1);
    rst = 1'b1;
    step(4'b1011, 8'hFF);
    rst = 1'b0;
    check("R9 reset over rotate", 8'h00, 1'b0);
    step(4'b0000, 8'h00);
    check("R1 load zero", 8'h00, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule